// File: doc/BRIEF.md
# Reverse Polish Stack Engine

This block is the control and storage core of a reverse Polish calculator. It accepts already-decoded 5-bit key codes, each qualified by a one-cycle valid strobe. It keeps one working entry, the key register. It also keeps a four-level operand stack. Every value in the block is four BCD digits plus a sign bit, 17 bits in all. Bit 16 is the sign: 1 means negative and 0 means positive. The low 16 bits are the digits.

The key register behaves as an implicit top of stack. Digit keys build a number in it. ENTER copies it onto the stack and leaves its own value unchanged. An operator key pops the shallowest stack level and presents that level with the key register to an external arithmetic unit through a request/done port pair. The value that comes back is written into the key register. Two clear keys empty either the key register or the stack. The arithmetic unit, the key decoding and the display are outside this block. The key register value is brought out for display.

A small controller with a central idle state accepts keys only while idle. Any key that arrives while the controller is busy is dropped. The controller drives the stack with a 2-bit mode: 00 hold, 01 push, 10 pop, 11 clear.

Top module: `rpn_core`

## Requirements
- R1: After reset the key register reads 17'h00000, opReq is low, stackOverflow is low and opA (the shallowest stack level) reads 17'h00000.
- R2: Codes 5'h00 to 5'h09 are digits. In a fresh entry, successive digits fill nibbles from bit 0 upward, so keys 2, 1, 3, 7 give 16'h7312. A fifth digit is ignored. The result of a key is visible two clock edges after the key is sampled.
- R3: Code 5'h0A (ENTER) pushes the key register onto the stack and leaves the key register unchanged. The next digit then starts a fresh entry: the other nibbles are zero and the sign is 0.
- R4: Code 5'h0C (add, opSel 2'b00) and code 5'h1C (subtract, opSel 2'b01) raise opReq for exactly one cycle, beginning one edge after the key is sampled. In that cycle opA is the shallowest stack level and opB is the key register.
- R5: An operator pops the stack. Each level moves one step shallower and the deepest level is loaded with zero.
- R6: After an operator the block waits for opDone. On the edge where opDone is high, opResult is loaded into the key register, and the next digit starts a fresh entry.
- R7: Code 5'h0B clears only the key register. The stack keeps its contents.
- R8: Code 5'h1B clears all four stack levels and the overflow flag. The key register is left as it was.
- R9: A push while all four levels hold entered values discards the deepest value and sets stackOverflow. The flag stays set through later pushes and pops until it is cleared by code 5'h1B.
- R10: Codes not listed above are ignored. Keys presented while an operation is waiting for opDone are also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| keyValid | input | 1 | Qualifies keyCode for one cycle |
| keyCode | input | 5 | Decoded key code |
| opDone | input | 1 | Arithmetic result is ready |
| opResult | input | 17 | Arithmetic result, sign in bit 16 |
| opReq | output | 1 | One-cycle request to the arithmetic unit |
| opSel | output | 2 | Operation select, 00 add, 01 subtract |
| opA | output | 17 | Shallowest stack level (operand 1) |
| opB | output | 17 | Key register (operand 2) |
| khrValue | output | 17 | Key register, for display |
| stackOverflow | output | 1 | Sticky stack overflow flag |

## Verification
A key that is sampled on one rising edge moves the controller into a one-cycle action state, so key register and stack changes land on the next edge. The bench therefore holds each key from one falling edge to the next and reads the results one full cycle later, at the second falling edge. The operator request is combinational from the action state, so opReq, opA, opB and opSel are read at the first falling edge. The loaded result is read at the falling edge that follows the cycle in which opDone is driven high. Stack contents are not visible directly; they are checked through opA on a chain of operators, which also covers the pop fill and the overflow discard.

// File: rtl/rpn_pkg.sv
package rpn_pkg;

  typedef enum logic [1:0] {
    SM_HOLD  = 2'b00,
    SM_PUSH  = 2'b01,
    SM_POP   = 2'b10,
    SM_CLEAR = 2'b11
  } stack_mode_e;

  localparam logic [4:0] KEY_ENTER = 5'h0A;
  localparam logic [4:0] KEY_CLX   = 5'h0B;
  localparam logic [4:0] KEY_ADD   = 5'h0C;
  localparam logic [4:0] KEY_CLR   = 5'h1B;
  localparam logic [4:0] KEY_SUB   = 5'h1C;
  localparam logic [4:0] KEY_LAST_DIGIT = 5'h09;

  typedef struct packed {
    stack_mode_e stackMode;
    logic        digitLoad;
    logic [3:0]  digit;
    logic        khrClear;
    logic        resultLoad;
  } ctl_t;

endpackage

// File: rtl/rpn_ctrl.sv
module rpn_ctrl
  import rpn_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       keyValid,
  input  logic [4:0] keyCode,
  input  logic       opDone,
  output ctl_t       ctl,
  output logic       opReq,
  output logic [1:0] opSel
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_NUM, ST_ENTER, ST_CAL, ST_WAIT, ST_CLX, ST_CLR
  } state_e;

  state_e     state, stateNext;
  logic [4:0] codeReg;

  always_comb begin
    stateNext = ST_IDLE;
    unique case (state)
      ST_IDLE: begin
        stateNext = ST_IDLE;
        if (keyValid) begin
          if (keyCode <= KEY_LAST_DIGIT)                       stateNext = ST_NUM;
          else if (keyCode == KEY_ENTER)                       stateNext = ST_ENTER;
          else if (keyCode == KEY_ADD || keyCode == KEY_SUB)   stateNext = ST_CAL;
          else if (keyCode == KEY_CLX)                         stateNext = ST_CLX;
          else if (keyCode == KEY_CLR)                         stateNext = ST_CLR;
          else                                                 stateNext = ST_IDLE;
        end
      end
      ST_CAL:  stateNext = ST_WAIT;
      ST_WAIT: stateNext = opDone ? ST_IDLE : ST_WAIT;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      codeReg <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_IDLE && keyValid) codeReg <= keyCode;
    end
  end

  always_comb begin
    ctl            = '0;
    ctl.stackMode  = SM_HOLD;
    ctl.digit      = codeReg[3:0];
    unique case (state)
      ST_NUM:   ctl.digitLoad  = 1'b1;
      ST_ENTER: ctl.stackMode  = SM_PUSH;
      ST_CAL:   ctl.stackMode  = SM_POP;
      ST_WAIT:  ctl.resultLoad = opDone;
      ST_CLX:   ctl.khrClear   = 1'b1;
      ST_CLR:   ctl.stackMode  = SM_CLEAR;
      default:  ;
    endcase
  end

  assign opReq = (state == ST_CAL);
  assign opSel = opReq ? {1'b0, codeReg[4]} : 2'b00;

endmodule

// File: rtl/rpn_dpath.sv
module rpn_dpath
  import rpn_pkg::*;
#(
  parameter int DIGITS = 4,
  parameter int LEVELS = 4,
  localparam int W      = 4 * DIGITS + 1,
  localparam int CNTW   = $clog2(DIGITS + 1),
  localparam int DEPTHW = $clog2(LEVELS + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  ctl_t         ctl,
  input  logic [W-1:0] opResult,
  output logic [W-1:0] khrValue,
  output logic [W-1:0] topLevel,
  output logic         stackOverflow
);

  logic [W-1:0]      khr;
  logic [CNTW-1:0]   digitCount;
  logic              fresh;
  logic [W-1:0]      stackMem [LEVELS];
  logic [DEPTHW-1:0] depth;
  logic              ovf;

  // key register: digit assembly, result load and clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      khr        <= '0;
      digitCount <= '0;
      fresh      <= 1'b0;
    end else if (ctl.khrClear) begin
      khr        <= '0;
      digitCount <= '0;
      fresh      <= 1'b0;
    end else if (ctl.resultLoad) begin
      khr   <= opResult;
      fresh <= 1'b1;
    end else if (ctl.stackMode == SM_PUSH || ctl.stackMode == SM_POP) begin
      fresh <= 1'b1;
    end else if (ctl.digitLoad) begin
      if (fresh) begin
        khr        <= {{(W-4){1'b0}}, ctl.digit};
        digitCount <= CNTW'(1);
        fresh      <= 1'b0;
      end else if (digitCount < CNTW'(DIGITS)) begin
        for (int i = 0; i < DIGITS; i++)
          if (digitCount == CNTW'(i)) khr[4*i +: 4] <= ctl.digit;
        digitCount <= digitCount + 1'b1;
      end
    end
  end

  // stack levels, index 0 is the shallowest
  for (genvar g = 0; g < LEVELS; g++) begin : g_level
    logic [W-1:0] pushSrc, popSrc;
    if (g == 0) begin : g_top
      assign pushSrc = khr;
    end else begin : g_inner
      assign pushSrc = stackMem[g-1];
    end
    if (g == LEVELS - 1) begin : g_deep
      assign popSrc = '0;
    end else begin : g_upper
      assign popSrc = stackMem[g+1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stackMem[g] <= '0;
      else begin
        unique case (ctl.stackMode)
          SM_PUSH:  stackMem[g] <= pushSrc;
          SM_POP:   stackMem[g] <= popSrc;
          SM_CLEAR: stackMem[g] <= '0;
          default:  ;
        endcase
      end
    end
  end

  // occupancy and sticky overflow
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth <= '0;
      ovf   <= 1'b0;
    end else begin
      unique case (ctl.stackMode)
        SM_PUSH: begin
          if (depth == DEPTHW'(LEVELS)) ovf <= 1'b1;
          else depth <= depth + 1'b1;
        end
        SM_POP:   if (depth != '0) depth <= depth - 1'b1;
        SM_CLEAR: begin
          depth <= '0;
          ovf   <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign khrValue      = khr;
  assign topLevel      = stackMem[0];
  assign stackOverflow = ovf;

endmodule

// File: rtl/rpn_core.sv
module rpn_core
  import rpn_pkg::*;
#(
  parameter int DIGITS = 4,
  parameter int LEVELS = 4,
  localparam int W = 4 * DIGITS + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         keyValid,
  input  logic [4:0]   keyCode,
  input  logic         opDone,
  input  logic [W-1:0] opResult,
  output logic         opReq,
  output logic [1:0]   opSel,
  output logic [W-1:0] opA,
  output logic [W-1:0] opB,
  output logic [W-1:0] khrValue,
  output logic         stackOverflow
);

  ctl_t ctl;

  rpn_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .keyValid (keyValid),
    .keyCode  (keyCode),
    .opDone   (opDone),
    .ctl      (ctl),
    .opReq    (opReq),
    .opSel    (opSel)
  );

  rpn_dpath #(.DIGITS(DIGITS), .LEVELS(LEVELS)) u_dpath (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctl           (ctl),
    .opResult      (opResult),
    .khrValue      (khrValue),
    .topLevel      (opA),
    .stackOverflow (stackOverflow)
  );

  assign opB = khrValue;

endmodule

// File: rtl/rpn_core_chk.sv
module rpn_core_chk
  import rpn_pkg::*;
#(
  parameter int W = 17
) (
  input logic         clk,
  input logic         rst_n,
  input ctl_t         ctl,
  input logic         opReq,
  input logic [W-1:0] opResult,
  input logic [W-1:0] khrValue,
  input logic         stackOverflow
);

  p_opreq_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    opReq |=> !opReq);

  p_enter_keeps_khr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.stackMode == SM_PUSH |=> $stable(khrValue));

  p_result_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.resultLoad |=> khrValue == $past(opResult));

  p_clx_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.khrClear |=> khrValue == '0);

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stackOverflow && ctl.stackMode != SM_CLEAR) |=> stackOverflow);

  p_clr_drops_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.stackMode == SM_CLEAR |=> !stackOverflow);

endmodule

bind rpn_core rpn_core_chk #(.W(W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ctl           (ctl),
  .opReq         (opReq),
  .opResult      (opResult),
  .khrValue      (khrValue),
  .stackOverflow (stackOverflow)
);

// File: tb/rpn_core_bench.sv
module rpn_core_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W = 17;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         keyValid = 1'b0;
  logic [4:0]   keyCode = '0;
  logic         opDone = 1'b0;
  logic [W-1:0] opResult = '0;
  logic         opReq;
  logic [1:0]   opSel;
  logic [W-1:0] opA, opB, khrValue;
  logic         stackOverflow;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rpn_core u_rpn_core (
    .clk(clk), .rst_n(rst_n), .keyValid(keyValid), .keyCode(keyCode),
    .opDone(opDone), .opResult(opResult), .opReq(opReq), .opSel(opSel),
    .opA(opA), .opB(opB), .khrValue(khrValue), .stackOverflow(stackOverflow)
  );

  // {key code, expected key register digits}, walked from reset
  localparam logic [20:0] VEC [12] = '{
    {5'h02, 16'h0002},  // R2 first digit low nibble
    {5'h01, 16'h0012},  // R2
    {5'h03, 16'h0312},  // R2
    {5'h07, 16'h7312},  // R2 four digits
    {5'h09, 16'h7312},  // R2 fifth digit ignored
    {5'h0A, 16'h7312},  // R3 ENTER keeps key register
    {5'h05, 16'h0005},  // R3 fresh entry after ENTER
    {5'h15, 16'h0005},  // R10 unlisted code
    {5'h0B, 16'h0000},  // R7 CLX
    {5'h04, 16'h0004},  // R2
    {5'h1F, 16'h0004},  // R10 unlisted code
    {5'h08, 16'h0084}   // R2
  };

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic press(input logic [4:0] code);
    keyValid = 1'b1;
    keyCode  = code;
    @(negedge clk);
    keyValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic doOp(input logic [4:0] code, input logic [W-1:0] expA,
                      input logic [W-1:0] expB, input logic [1:0] expSel,
                      input logic [W-1:0] result, input string tag);
    keyValid = 1'b1;
    keyCode  = code;
    @(negedge clk);
    keyValid = 1'b0;
    chk({tag, " R4 opReq"}, W'(opReq), W'(1));
    chk({tag, " R4/R5 opA"}, opA, expA);
    chk({tag, " R4 opB"}, opB, expB);
    chk({tag, " R4 opSel"}, W'(opSel), W'(expSel));
    @(negedge clk);
    chk({tag, " R4 opReq drop"}, W'(opReq), W'(0));
    opDone   = 1'b1;
    opResult = result;
    @(negedge clk);
    opDone = 1'b0;
    chk({tag, " R6 result"}, khrValue, result);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 khr", khrValue, '0);
    chk("R1 opReq", W'(opReq), W'(0));
    chk("R1 ovf", W'(stackOverflow), W'(0));
    chk("R1 opA", opA, '0);

    // table of digit / ENTER / clear / ignored keys
    for (int i = 0; i < 12; i++) begin
      press(VEC[i][20:16]);
      chk($sformatf("R2/R3/R7/R10 vec%0d", i), khrValue, {1'b0, VEC[i][15:0]});
    end

    // R4 add: stack holds 7312, key register 0084
    doOp(5'h0C, 17'h07312, 17'h00084, 2'b00, 17'h07396, "add");
    press(5'h01);
    chk("R6 fresh after result", khrValue, 17'h00001);

    // R4 subtract with negative result
    press(5'h0A);
    press(5'h05);
    doOp(5'h1C, 17'h00001, 17'h00005, 2'b01, 17'h10004, "sub");
    press(5'h03);
    chk("R3 fresh clears sign", khrValue, 17'h00003);

    // R10 key during wait is ignored
    press(5'h0A);
    keyValid = 1'b1;
    keyCode  = 5'h0C;
    @(negedge clk);
    keyValid = 1'b0;
    chk("R4 opA wait case", opA, 17'h00003);
    @(negedge clk);
    keyValid = 1'b1;
    keyCode  = 5'h09;
    @(negedge clk);
    keyValid = 1'b0;
    chk("R10 key in wait khr", khrValue, 17'h00003);
    chk("R10 key in wait opReq", W'(opReq), W'(0));
    opDone   = 1'b1;
    opResult = 17'h00006;
    @(negedge clk);
    opDone = 1'b0;
    chk("R6 load after wait", khrValue, 17'h00006);
    @(negedge clk);
    chk("R10 no late digit", khrValue, 17'h00006);

    // R9 overflow on the fifth push, R5 pop fill
    press(5'h1B);
    for (int v = 1; v <= 5; v++) begin
      press(5'(v));
      press(5'h0A);
      if (v == 4) chk("R9 four pushes no ovf", W'(stackOverflow), W'(0));
    end
    chk("R9 fifth push ovf", W'(stackOverflow), W'(1));
    doOp(5'h0C, 17'h00005, 17'h00005, 2'b00, 17'h00000, "pop1");
    doOp(5'h0C, 17'h00004, 17'h00000, 2'b00, 17'h00000, "pop2");
    doOp(5'h0C, 17'h00003, 17'h00000, 2'b00, 17'h00000, "pop3");
    doOp(5'h0C, 17'h00002, 17'h00000, 2'b00, 17'h00000, "R9 deepest kept");
    doOp(5'h0C, 17'h00000, 17'h00000, 2'b00, 17'h00000, "R5 zero fill");
    chk("R9 ovf sticky", W'(stackOverflow), W'(1));
    press(5'h1B);
    chk("R8 ovf cleared", W'(stackOverflow), W'(0));

    // R7 CLX leaves the stack
    press(5'h06);
    press(5'h0A);
    press(5'h0B);
    chk("R7 khr cleared", khrValue, 17'h00000);
    doOp(5'h0C, 17'h00006, 17'h00000, 2'b00, 17'h00000, "R7 stack kept");

    // R8 CLR empties stack, keeps key register
    press(5'h09);
    press(5'h0A);
    press(5'h1B);
    chk("R8 khr kept", khrValue, 17'h00009);
    doOp(5'h0C, 17'h00000, 17'h00009, 2'b00, 17'h00000, "R8 stack cleared");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule